// File: doc/BRIEF.md
# Window/Timeout Watchdog Controller

This block supervises a host processor with a watchdog that runs in one of three modes: Window, Timeout or Off. The mode follows from the system operating state, an external disable pin and a mode-control bit held in the watchdog control register. A 3-bit period code picks the watchdog period from a power-of-two table measured in 1 ms ticks. Every write to the watchdog control register counts as a trigger and restarts the period counter.

In Window mode a trigger that comes too early, or no trigger at all before the period ends, raises a one-cycle system-reset request. In Timeout mode an overflow asks the interrupt logic to set the cyclic interrupt flag; when that flag is already pending, the overflow raises a reset instead. Toggling the disable pin, or flipping the mode bit while the system runs normally, also raises a reset. After any watchdog reset the period code falls back to its default.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, rst_req_o and ci_set_o are 0, period_o is 3'b100 and mode_bit_o is 0.
- R2: wd_mode_o (0 Off, 1 Window, 2 Timeout) follows sys_mode_i (0 Off, 1 Overtemp, 2 Sleep, 3 Standby, 4 Normal): disable pin high gives Off; Normal gives Window with mode bit 0 and Timeout with mode bit 1; Standby gives Timeout with mode bit 0 and Off with mode bit 1; every other system state gives Off.
- R3: Period code c sets a period of 2^(c+BASE_LOG2) ticks, so code 3'b100 with the default BASE_LOG2 of 3 is 128 ticks.
- R4: In Window mode, a trigger while fewer than half a period of ticks have passed since the counter restarted requests a system reset.
- R5: In Window mode, a trigger at or after the half-period point and before overflow restarts the counter and requests no reset.
- R6: In Window mode, a full period of ticks without a trigger requests a system reset.
- R7: In Timeout mode an overflow pulses ci_set_o when ci_pending_i is low, and requests a reset instead when ci_pending_i is high; the counter restarts in both cases.
- R8: In Timeout mode a trigger at any count restarts the counter without any reset or interrupt request.
- R9: A change on dis_pin_i while sys_mode_i is Normal or Standby requests a reset; a change in any other system state does not.
- R10: A write that changes the mode bit while sys_mode_i is Normal requests a reset, and the new bit value is stored.
- R11: In Standby, a write while irq_pending_i is high leaves the mode bit unchanged; with irq_pending_i low the write updates it.
- R12: In Standby with the mode bit at 1, a high irq_pending_i turns the watchdog back on in Timeout mode.
- R13: A watchdog reset returns the period code to 3'b100 and restarts the counter from zero.
- R14: rst_req_o and ci_set_o are registered pulses, high in the cycle after the clock edge that samples the triggering condition and low after the following edge unless a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 ms time-base strobe |
| sys_mode_i | input | 3 | System operating state code |
| dis_pin_i | input | 1 | External watchdog disable pin |
| wr_en_i | input | 1 | Write strobe to the watchdog control register (trigger) |
| wr_period_i | input | 3 | Period code carried by the write |
| wr_mode_bit_i | input | 1 | Mode-control bit carried by the write |
| irq_pending_i | input | 1 | Any interrupt is pending |
| ci_pending_i | input | 1 | Cyclic interrupt flag is pending |
| rst_req_o | output | 1 | System-reset request pulse |
| ci_set_o | output | 1 | Request to set the cyclic interrupt flag |
| period_o | output | 3 | Current period code |
| mode_bit_o | output | 1 | Current mode-control bit |
| wd_mode_o | output | 2 | Current watchdog mode |

## Verification
The mode output is combinational and is sampled half a cycle after its inputs change. A reset or interrupt request is due one cycle after the edge that samples its cause: after a restart edge, an overflow request appears exactly one period of ticks later, and a trigger's verdict appears right after the edge that samples the write. The bench holds the tick high and drives inputs at falling edges, so it counts edges from each restart and samples at the falling edge that follows the edge where the pulse is due, sweeping every trigger offset inside the period for several period codes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [2:0] {
    SYS_OFF      = 3'd0,
    SYS_OVERTEMP = 3'd1,
    SYS_SLEEP    = 3'd2,
    SYS_STANDBY  = 3'd3,
    SYS_NORMAL   = 3'd4
  } sys_mode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_WINDOW  = 2'd1,
    WD_TIMEOUT = 2'd2
  } wd_mode_e;

  localparam logic [2:0] DEF_PERIOD = 3'b100;
endpackage

// File: rtl/wdog_mode_dec.sv
module wdog_mode_dec
  import wdog_pkg::*;
(
  input  logic [2:0] sys_mode_i,
  input  logic       dis_pin_i,
  input  logic       mode_bit_i,
  input  logic       irq_pending_i,
  output wd_mode_e   mode_o
);
  always_comb begin
    mode_o = WD_OFF;
    if (!dis_pin_i) begin
      unique case (sys_mode_i)
        SYS_NORMAL:  mode_o = mode_bit_i ? WD_TIMEOUT : WD_WINDOW;
        SYS_STANDBY: mode_o = (!mode_bit_i || irq_pending_i) ? WD_TIMEOUT : WD_OFF;
        default:     mode_o = WD_OFF;
      endcase
    end
  end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_period_i,
  input  logic       wr_mode_bit_i,
  input  logic       lock_i,
  input  logic       wd_rst_i,
  output logic [2:0] period_o,
  output logic       mode_bit_o
);
  logic [2:0] period_q, period_d;
  logic       mb_q, mb_d;

  always_comb begin
    period_d = period_q;
    if (wd_rst_i)     period_d = DEF_PERIOD;
    else if (wr_en_i) period_d = wr_period_i;
  end

  always_comb begin
    mb_d = mb_q;
    if (wr_en_i && !lock_i) mb_d = wr_mode_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= DEF_PERIOD;
      mb_q     <= 1'b0;
    end else begin
      period_q <= period_d;
      mb_q     <= mb_d;
    end
  end

  assign period_o   = period_q;
  assign mode_bit_o = mb_q;

  // R11: a locked write leaves the mode bit untouched
  p_lock_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_i) |=> (mb_q == $past(mb_q)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_LOG2 = 3,
  localparam int CW = BASE_LOG2 + 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       early_o,
  output logic       ovf_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] period_ticks;
  logic [CW-1:0] half_ticks;
  logic          cnt_en;

  assign period_ticks = {{(CW-1){1'b0}}, 1'b1} << (CW'(code_i) + CW'(BASE_LOG2));
  assign half_ticks   = period_ticks >> 1;
  assign early_o      = cnt_q < half_ticks;
  assign ovf_o        = run_i && tick_i && (cnt_q == period_ticks - 1'b1);
  assign cnt_en       = !run_i || restart_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || restart_i) cnt_d = '0;
    else if (tick_i)         cnt_d = ovf_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the count never reaches the selected period length
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_ticks);
  // R2: an idle watchdog holds its count at zero
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] sys_mode_i,
  input  logic       dis_pin_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_period_i,
  input  logic       wr_mode_bit_i,
  input  logic       irq_pending_i,
  input  logic       ci_pending_i,
  output logic       rst_req_o,
  output logic       ci_set_o,
  output logic [2:0] period_o,
  output logic       mode_bit_o,
  output logic [1:0] wd_mode_o
);
  wd_mode_e   mode_now, mode_q;
  logic [2:0] period;
  logic       mode_bit;
  logic       early, ovf;
  logic       dis_q, seen_q;
  logic       rst_q, ci_q;
  logic       in_normal, in_standby;
  logic       trig, lock, mode_chg;
  logic       ev_early, ev_win_ovf, ev_to_rst, ev_mb_chg, ev_dis_chg;
  logic       rst_evt, ci_evt, restart;

  wdog_mode_dec u_dec (
    .sys_mode_i    (sys_mode_i),
    .dis_pin_i     (dis_pin_i),
    .mode_bit_i    (mode_bit),
    .irq_pending_i (irq_pending_i),
    .mode_o        (mode_now)
  );

  assign in_normal  = (sys_mode_i == SYS_NORMAL);
  assign in_standby = (sys_mode_i == SYS_STANDBY);
  assign lock       = in_standby && irq_pending_i;
  assign trig       = wr_en_i && (mode_now != WD_OFF);
  assign mode_chg   = (mode_now != mode_q);

  // reset and interrupt event sources
  assign ev_early   = trig && (mode_now == WD_WINDOW) && early;
  assign ev_win_ovf = ovf && !trig && (mode_now == WD_WINDOW);
  assign ev_to_rst  = ovf && !trig && (mode_now == WD_TIMEOUT) && ci_pending_i;
  assign ev_mb_chg  = wr_en_i && in_normal && (wr_mode_bit_i != mode_bit);
  assign ev_dis_chg = seen_q && (dis_pin_i != dis_q) && (in_normal || in_standby);

  assign rst_evt = ev_early | ev_win_ovf | ev_to_rst | ev_mb_chg | ev_dis_chg;
  assign ci_evt  = ovf && !trig && (mode_now == WD_TIMEOUT) && !ci_pending_i && !rst_evt;
  assign restart = trig | rst_evt | mode_chg;

  wdog_cfg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_period_i   (wr_period_i),
    .wr_mode_bit_i (wr_mode_bit_i),
    .lock_i        (lock),
    .wd_rst_i      (rst_evt),
    .period_o      (period),
    .mode_bit_o    (mode_bit)
  );

  wdog_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_now != WD_OFF),
    .tick_i    (tick_i),
    .restart_i (restart),
    .code_i    (period),
    .early_o   (early),
    .ovf_o     (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q  <= 1'b0;
      seen_q <= 1'b0;
      mode_q <= WD_OFF;
      rst_q  <= 1'b0;
      ci_q   <= 1'b0;
    end else begin
      dis_q  <= dis_pin_i;
      seen_q <= 1'b1;
      mode_q <= mode_now;
      rst_q  <= rst_evt;
      ci_q   <= ci_evt;
    end
  end

  assign rst_req_o  = rst_q;
  assign ci_set_o   = ci_q;
  assign period_o   = period;
  assign mode_bit_o = mode_bit;
  assign wd_mode_o  = mode_now;

  // R7: a single overflow never asks for both outcomes
  p_ci_xor_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ci_set_o |-> !rst_req_o);
  // R13: every reset pulse comes with the default period code
  p_rst_default_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (period_o == DEF_PERIOD));
  // R4: an early window trigger is answered in the next cycle
  p_early_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wd_mode_o == 2'd1) && early) |=> rst_req_o);
  // R12: with the bit set in Standby, a pending interrupt keeps the watchdog on
  p_irq_wake_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_standby && !dis_pin_i && irq_pending_i) |-> (wd_mode_o == 2'd2));
endmodule

// File: tb/tb_wdog_ctrl.sv
module tb_wdog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 1;

  logic       clk, rst_n, tick;
  logic [2:0] sys_mode;
  logic       dis_pin, wr_en, wr_mb, irq_pend, ci_pend;
  logic [2:0] wr_period;
  logic       rst_req, ci_set, mode_bit;
  logic [2:0] period;
  logic [1:0] wd_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wdog_ctrl #(.BASE_LOG2(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sys_mode_i(sys_mode),
    .dis_pin_i(dis_pin), .wr_en_i(wr_en), .wr_period_i(wr_period),
    .wr_mode_bit_i(wr_mb), .irq_pending_i(irq_pend), .ci_pending_i(ci_pend),
    .rst_req_o(rst_req), .ci_set_o(ci_set), .period_o(period),
    .mode_bit_o(mode_bit), .wd_mode_o(wd_mode)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] code, input logic mb);
    wr_en = 1; wr_period = code; wr_mb = mb;
    step();
    wr_en = 0;
  endtask

  // leaves the counter at zero in Window mode with the given code
  task automatic restart_window(input logic [2:0] code);
    sys_mode = 3'd3;
    do_write(code, 1'b0);
    sys_mode = 3'd4;
    step();
  endtask

  function automatic int exp_mode(input int s, input int mb, input int d, input int irq);
    if (d) return 0;
    if (s == 4) return mb ? 2 : 1;
    if (s == 3) return (!mb || irq) ? 2 : 0;
    return 0;
  endfunction

  task automatic count_until_rst(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (rst_req) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, p;
    rst_n = 0; tick = 1; sys_mode = 3'd0; dis_pin = 0; wr_en = 0;
    wr_period = 0; wr_mb = 0; irq_pend = 0; ci_pend = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rst_req == 0 && ci_set == 0, "R1 pulses", {rst_req, ci_set}, 0);
    chk(period == 3'b100, "R1 period", period, 4);
    chk(mode_bit == 0, "R1 mode bit", mode_bit, 0);
    rst_n = 1;
    step();

    // R2 mode decode sweep
    for (int mb = 0; mb < 2; mb++) begin
      sys_mode = 3'd0; dis_pin = 0; step();
      do_write(3'd4, mb[0]);
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 5; s++) begin
          sys_mode = s[2:0]; dis_pin = d[0];
          step();
          chk(wd_mode == exp_mode(s, mb, d, 0), "R2 mode", wd_mode, exp_mode(s, mb, d, 0));
        end
    end
    sys_mode = 3'd0; dis_pin = 0; step();
    do_write(3'd4, 1'b0);

    // R4/R5 window trigger offset sweep
    for (int c = 0; c < 5; c++) begin
      p = 1 << (c + BASE);
      for (int k = 0; k < p; k++) begin
        restart_window(c[2:0]);
        for (int j = 0; j < k; j++) step();
        do_write(c[2:0], 1'b0);
        if (k < p/2) chk(rst_req == 1, "R4 early trigger", rst_req, 1);
        else         chk(rst_req == 0, "R5 open-window trigger", rst_req, 0);
      end
    end

    // R6/R3 window overflow timing per code, R14 pulse width
    for (int c = 0; c < 5; c++) begin
      p = 1 << (c + BASE);
      restart_window(c[2:0]);
      count_until_rst(p + 4, n);
      chk(n == p, "R6 R3 window overflow cycles", n, p);
      chk(period == 3'b100, "R13 period default", period, 4);
      step();
      chk(rst_req == 0, "R14 one-cycle pulse", rst_req, 0);
    end
    // R13 counter restarts from zero after the reset
    restart_window(3'd0);
    count_until_rst(8, n);
    count_until_rst(64, n);
    chk(n == (1 << (4 + BASE)), "R13 restart after reset", n, 1 << (4 + BASE));

    // R7 timeout overflow: interrupt then reset
    sys_mode = 3'd3;
    do_write(3'd1, 1'b0);
    p = 1 << (1 + BASE);
    n = 0;
    for (int i = 1; i <= p + 4; i++) begin
      step();
      if (ci_set) begin n = i; break; end
    end
    chk(n == p, "R7 timeout sets interrupt", n, p);
    chk(rst_req == 0, "R7 no reset with flag clear", rst_req, 0);
    ci_pend = 1;
    count_until_rst(p + 4, n);
    chk(n == p, "R7 timeout reset with flag pending", n, p);
    chk(ci_set == 0, "R7 no interrupt with flag pending", ci_set, 0);
    ci_pend = 0;

    // R8 timeout trigger restarts at any count
    do_write(3'd1, 1'b0);
    do_write(3'd1, 1'b0);
    chk(rst_req == 0 && ci_set == 0, "R8 immediate trigger", {rst_req, ci_set}, 0);
    for (int j = 0; j < p - 1; j++) step();
    do_write(3'd1, 1'b0);
    chk(rst_req == 0 && ci_set == 0, "R8 late trigger", {rst_req, ci_set}, 0);
    n = 0;
    for (int i = 1; i <= p + 4; i++) begin
      step();
      if (ci_set) begin n = i; break; end
    end
    chk(n == p, "R8 counter restarted", n, p);

    // R9 disable pin changes
    sys_mode = 3'd4; dis_pin = 0; step();
    dis_pin = 1; step();
    chk(rst_req == 1, "R9 pin rise in Normal", rst_req, 1);
    step();
    chk(rst_req == 0, "R14 pin pulse ends", rst_req, 0);
    dis_pin = 0; step();
    chk(rst_req == 1, "R9 pin fall in Normal", rst_req, 1);
    sys_mode = 3'd2; step();
    dis_pin = 1; step();
    chk(rst_req == 0, "R9 pin change in Sleep ignored", rst_req, 0);
    dis_pin = 0; step();
    chk(rst_req == 0, "R9 pin change in Sleep ignored", rst_req, 0);
    sys_mode = 3'd3; step();
    dis_pin = 1; step();
    chk(rst_req == 1, "R9 pin change in Standby", rst_req, 1);
    dis_pin = 0; step();

    // R10 mode bit change in Normal
    restart_window(3'd0);
    step();
    do_write(3'd0, 1'b1);
    chk(rst_req == 1, "R10 mode bit change reset", rst_req, 1);
    chk(mode_bit == 1, "R10 bit stored", mode_bit, 1);

    // R11 lock in Standby, R12 interrupt re-enable
    sys_mode = 3'd3; step();
    do_write(3'd4, 1'b0);
    chk(mode_bit == 0, "R11 unlocked write", mode_bit, 0);
    chk(rst_req == 0, "R11 no reset in Standby", rst_req, 0);
    irq_pend = 1;
    do_write(3'd4, 1'b1);
    chk(mode_bit == 0, "R11 locked write ignored", mode_bit, 0);
    irq_pend = 0;
    do_write(3'd4, 1'b1);
    chk(mode_bit == 1, "R11 write after unlock", mode_bit, 1);
    chk(wd_mode == 0, "R12 off through mode bit", wd_mode, 0);
    irq_pend = 1; step();
    chk(wd_mode == 2, "R12 interrupt re-enables", wd_mode, 2);
    irq_pend = 0; step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule